// File: doc/BRIEF.md
# Falling-Edge Pulse Stretcher

This block watches one synchronous input level and drives one output level. The output follows the input up with no added delay. When the input drops, the output stays high for two further clock cycles and then falls. The rising edge is never delayed. Only the release is lengthened, and always by the same two clocks.

A two-bit state machine holds the behaviour. Its four encodings form a Gray-coded ring: idle, following, first tail cycle and second tail cycle. The output is a flip-flop loaded from a decode of the next state, so it changes only at clock edges. If the input rises again during the tail, the machine goes back to the following state. A later fall then starts a fresh, full two-cycle tail. A synchronous active-high reset forces the idle state with the output low.

Top module: `trail_stretch`

## Requirements
- R1: While `rst` is sampled high at a rising clock edge, `dout` is 0 after that edge, whatever `din` is. This holds even when the reset arrives in the middle of a tail.
- R2: When `din` is sampled 1 at an edge and `dout` was 0, `dout` is 1 after that same edge. The rising edge gets no delay.
- R3: While `din` stays sampled 1 over many edges, `dout` stays 1.
- R4: At the first edge where `din` is sampled 0 after being 1, `dout` stays 1. It is still 1 after the next edge. It becomes 0 after the edge that follows, provided `din` stays 0.
- R5: If `din` is sampled 1 again during the two-cycle tail, `dout` stays 1. The next fall then gets a complete two-cycle tail, counted from that new fall.
- R6: A `din` pulse that is sampled high at only one edge gives a `dout` pulse three cycles long.
- R7: With `din` held 0 and no tail pending, `dout` stays 0.
- R8: The state register uses all four two-bit codes: idle 00, following 01, tail-one 11, tail-two 10. Every code has a defined successor, so no code is left unused.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 1 | Level to be stretched, already synchronous to `clk` |
| dout | output | 1 | Registered stretched level |

## Verification
The hardest case to reach is a return of the input during the tail. The input must be high again in exactly the first or the second tail cycle, and the check must show that the later tail is a full two cycles and not what was left of the old one. The stimulus drops the input for one cycle, then for two cycles, each followed by a new high, and compares every cycle's output against a reference counter. A reset applied inside a tail is driven in the same way.

// File: rtl/trail_stretch_pkg.sv
package trail_stretch_pkg;
  localparam int STATE_W = 2;

  typedef enum logic [STATE_W-1:0] {
    ST_IDLE   = 2'b00,
    ST_FOLLOW = 2'b01,
    ST_TAIL1  = 2'b11,
    ST_TAIL2  = 2'b10
  } st_e;
endpackage

// File: rtl/trail_stretch_next.sv
module trail_stretch_next
  import trail_stretch_pkg::*;
(
  input  st_e  cur_i,
  input  logic din_i,
  output st_e  nxt_o
);
  always_comb begin
    if (din_i) begin
      nxt_o = ST_FOLLOW;
    end else begin
      unique case (cur_i)
        ST_FOLLOW: nxt_o = ST_TAIL1;
        ST_TAIL1:  nxt_o = ST_TAIL2;
        ST_TAIL2:  nxt_o = ST_IDLE;
        default:   nxt_o = ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/trail_stretch_state.sv
module trail_stretch_state
  import trail_stretch_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  st_e  nxt_i,
  output st_e  cur_o
);
  always_ff @(posedge clk) begin
    if (rst) cur_o <= ST_IDLE;
    else     cur_o <= nxt_i;
  end
endmodule

// File: rtl/trail_stretch_out.sv
module trail_stretch_out
  import trail_stretch_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  st_e  nxt_i,
  output logic q_o
);
  logic busy;
  assign busy = (nxt_i != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) q_o <= 1'b0;
    else     q_o <= busy;
  end
endmodule

// File: rtl/trail_stretch.sv
module trail_stretch
  import trail_stretch_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  st_e cur_st;
  st_e nxt_st;

  trail_stretch_next u_next (
    .cur_i (cur_st),
    .din_i (din),
    .nxt_o (nxt_st)
  );

  trail_stretch_state u_state (
    .clk   (clk),
    .rst   (rst),
    .nxt_i (nxt_st),
    .cur_o (cur_st)
  );

  trail_stretch_out u_out (
    .clk   (clk),
    .rst   (rst),
    .nxt_i (nxt_st),
    .q_o   (dout)
  );

  // R1: reset clears the output and the state
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!dout && cur_st == ST_IDLE));

  // R2: input sampled high drives the output high at once
  p_no_lead_delay_r2: assert property (@(posedge clk) disable iff (rst)
    din |=> dout);

  // R4: the first tail cycle keeps the output up
  p_tail_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (cur_st == ST_FOLLOW && !din) |=> (dout && cur_st == ST_TAIL1));

  // R4: the tail ends after its second cycle
  p_tail_end_r4: assert property (@(posedge clk) disable iff (rst)
    (cur_st == ST_TAIL2 && !din) |=> !dout);

  // R5: a new high during the tail goes back to following
  p_retrigger_r5: assert property (@(posedge clk) disable iff (rst)
    ((cur_st == ST_TAIL1 || cur_st == ST_TAIL2) && din) |=> (dout && cur_st == ST_FOLLOW));

  // R7: idle with a low input stays quiet
  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    (cur_st == ST_IDLE && !din) |=> !dout);

  // R8: output level agrees with the state code
  p_out_matches_state_r8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (dout == (cur_st != ST_IDLE)));
endmodule

// File: tb/sim_trail_stretch.sv
`timescale 1ns/1ps
module sim_trail_stretch;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic din = 1'b0;
  logic dout;

  always #2.5 clk = ~clk;

  trail_stretch u0 (.clk(clk), .rst(rst), .din(din), .dout(dout));

  int n_vec = 0;
  int n_bad = 0;
  int cycles = 0;
  bit exp_q[$];
  string tag_q[$];
  int ref_cnt = 0;
  bit done = 1'b0;

  // apply one cycle of stimulus and queue the expected output after the edge
  task automatic drive(input bit r, input bit d, input string tag);
    bit e;
    @(negedge clk);
    rst = r;
    din = d;
    if (r) begin
      e = 1'b0; ref_cnt = 0;
    end else if (d) begin
      e = 1'b1; ref_cnt = 2;
    end else if (ref_cnt > 0) begin
      e = 1'b1; ref_cnt--;
    end else begin
      e = 1'b0;
    end
    @(posedge clk);
    #1;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  // monitor: compare at each falling edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      bit e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_vec++;
      if (dout !== e) begin
        n_bad++;
        $display("FAIL %s: dout=%b expected %b at t=%0t", t, dout, e, $time);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000 && !done) begin
      n_bad++;
      $display("FAIL watchdog: cycles=%0d expected <=5000", cycles);
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state, with the input both high and low
    drive(1, 0, "R1");
    drive(1, 1, "R1");
    drive(1, 0, "R1");
    // R7: idle stays low
    for (int i = 0; i < 4; i++) drive(0, 0, "R7");
    // R2, R3: immediate rise and a long high
    drive(0, 1, "R2");
    for (int i = 0; i < 6; i++) drive(0, 1, "R3");
    // R4: tail of two cycles, then low
    for (int i = 0; i < 5; i++) drive(0, 0, "R4");
    // R6: single-cycle pulse
    drive(0, 1, "R6");
    for (int i = 0; i < 5; i++) drive(0, 0, "R6");
    // R5: return during tail cycle one, then during tail cycle two
    drive(0, 1, "R5");
    drive(0, 0, "R5");
    drive(0, 1, "R5");
    drive(0, 0, "R5");
    drive(0, 0, "R5");
    drive(0, 1, "R5");
    for (int i = 0; i < 5; i++) drive(0, 0, "R5");
    // R8: alternating pattern walks every state code
    for (int i = 0; i < 12; i++) drive(0, (i % 4) == 0, "R8");
    // R1: reset in the middle of a tail
    drive(0, 1, "R1");
    drive(0, 0, "R1");
    drive(1, 0, "R1");
    for (int i = 0; i < 3; i++) drive(0, 0, "R1");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule